// File: doc/BRIEF.md
# Register-Window Bridge with Index Remap

This block sits between a host's 64-bit memory-mapped slave window and an internal register bus. Each host access carries a byte address; the bridge masks it to the window, folds it into a compact register index by one of two selectable generation rules, and decides whether the access is answered locally or sent on. A handful of indices get a local answer: the chip identity, four region base and span values taken from configuration inputs, and a fixed set of log, status and fault-mask indices. The fixed set reads as zero, and writes to it are dropped.

Every other access goes to the register bus at the index times eight. The bridge then waits for an acknowledge, which may carry an error. Host data travels in big-endian byte order, while the register bus and the configuration values are native. Only one transaction is in flight at a time. Each finished access leaves sticky completion bits (done, and fail on a downstream error) that the host clears by pulsing a clear input.

Top module: `regbr_top`

## Requirements
- R1: An access whose `h_size` is anything other than 8 bytes completes with `h_err`=1 and `h_rdata`=0. It makes no downstream request and leaves `st_done` and `st_fail` unchanged.
- R2: Address bits at and above bit WIN_W have no effect on the index, the local answer or the downstream address.
- R3: With `mode_new`=1 the index is the masked address shifted right by 3. The downstream address is the index shifted left by 3, so address bits [2:0] are ignored.
- R4: With `mode_new`=0 the index is {addr[WIN_W-1:8], addr[6:3]}. Address bit 7 and bits [2:0] are dropped.
- R5: Host data uses big-endian lanes: host byte lane 0 (bits [7:0]) holds the most significant byte of the register value. The bridge byte-reverses write data on its way downstream, and it byte-reverses read data and local values on their way to the host.
- R6: A read of index 0x000F000F returns `cfg_ident` locally in either mode. A write to it is dropped without any downstream request.
- R7: A read of a region index returns the matching configuration value locally. In new mode the indices 0x5012B00, 0x5012B02, 0x5012B04 and 0x5012B06 return reg0 base, reg1 base, reg0 span and reg1 span. In legacy mode the indices 0x2013F00, 0x2013F02, 0x2013F04 and 0x2013F06 return the same four values. A region index of the other mode, and any write to a region index, is forwarded downstream.
- R8: Indices 0x1010C00, 0x1010C03, 0x0090012, 0x0090013, 0x0090018, 0x2020007, 0x2020009 and 0x202000F read as zero and ignore writes in both modes, with no downstream request.
- R9: Every correctly sized access that completes without a downstream error, whether local or forwarded, sets `st_done`.
- R10: A forwarded access whose acknowledge carries `d_err`=1 sets both `st_fail` and `st_done`, and it returns `h_rdata`=0.
- R11: `st_done` and `st_fail` stay set until `st_clr[0]` or `st_clr[1]` (respectively) is pulsed. Each clear bit affects only its own status bit.
- R12: One transaction is outstanding at a time. A local answer raises `h_ready` for one cycle, one cycle after acceptance. A forwarded access holds `d_req` with stable address and data until `d_ack`, and `h_ready` follows one cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_new | input | 1 | 1 selects the new-generation index rule, 0 the legacy rule |
| cfg_ident | input | 64 | Chip identity value |
| cfg_reg0_base | input | 64 | Region 0 base value |
| cfg_reg0_span | input | 64 | Region 0 span value |
| cfg_reg1_base | input | 64 | Region 1 base value |
| cfg_reg1_span | input | 64 | Region 1 span value |
| h_valid | input | 1 | Host request valid, held until `h_ready` |
| h_write | input | 1 | Host request is a write |
| h_addr | input | ADDR_W | Host byte address |
| h_size | input | 5 | Access size in bytes |
| h_wdata | input | 64 | Host write data, big-endian lanes |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 64 | Read data, big-endian lanes, valid with `h_ready` |
| h_err | output | 1 | Size error, valid with `h_ready` |
| d_req | output | 1 | Downstream request, held until `d_ack` |
| d_write | output | 1 | Downstream request is a write |
| d_addr | output | WIN_W | Downstream address (index times 8) |
| d_wdata | output | 64 | Downstream write data, native order |
| d_ack | input | 1 | Downstream acknowledge, one cycle |
| d_err | input | 1 | Acknowledge carries an error |
| d_rdata | input | 64 | Downstream read data, native order |
| st_clr | input | 2 | Clear pulses: bit 0 clears done, bit 1 clears fail |
| st_done | output | 1 | Sticky completion bit |
| st_fail | output | 1 | Sticky failure bit |

## Verification
The bench builds the bridge with ADDR_W=40 and keeps the default WIN_W=35. This leaves five address bits above the window, so the bench can set them and show that masking discards them. It also leaves the full 32-bit new-mode and 31-bit legacy index spaces intact, so every intercept index, and legacy addresses with bit 7 set, can be reached directly. Downstream latencies of zero to three cycles exercise the hold of the request and the placement of the `h_ready` pulse.

// File: rtl/regbr_pkg.sv
package regbr_pkg;

    localparam int unsigned DATA_W     = 64;
    localparam int unsigned ACC_BYTES  = 8;
    localparam int unsigned N_REGION   = 4;
    localparam int unsigned N_SWALLOW  = 8;

    // What the bridge does with one access
    typedef enum logic [1:0] {
        ACT_FWD   = 2'd0,
        ACT_VALUE = 2'd1,
        ACT_ZERO  = 2'd2
    } act_e;

    // Which local value answers a read
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_IDENT = 3'd1,
        SRC_R0B   = 3'd2,
        SRC_R1B   = 3'd3,
        SRC_R0S   = 3'd4,
        SRC_R1S   = 3'd5
    } src_e;

    typedef struct packed {
        act_e act;
        src_e src;
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    localparam logic [31:0] IDX_IDENT = 32'h000F_000F;

    // Region order: reg0 base, reg1 base, reg0 span, reg1 span (src = SRC_R0B + k)
    localparam logic [31:0] REGION_NEW [N_REGION] = '{
        32'h0501_2B00, 32'h0501_2B02, 32'h0501_2B04, 32'h0501_2B06
    };
    localparam logic [31:0] REGION_LEG [N_REGION] = '{
        32'h0201_3F00, 32'h0201_3F02, 32'h0201_3F04, 32'h0201_3F06
    };

    localparam logic [31:0] SWALLOW_IDX [N_SWALLOW] = '{
        32'h0101_0C00, 32'h0101_0C03, 32'h0009_0012, 32'h0009_0013,
        32'h0009_0018, 32'h0202_0007, 32'h0202_0009, 32'h0202_000F
    };

    // Reverse byte order between big-endian host lanes and native values
    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < ACC_BYTES; b++) begin
            r[8*b +: 8] = v[8*(ACC_BYTES-1-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/regbr_fold.sv
module regbr_fold
    import regbr_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int WIN_W  = 35,
    parameter int IDX_W  = WIN_W - 3
) (
    input  logic              mode_new,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int LEG_W = WIN_W - 4;

    logic [WIN_W-1:0] win;
    logic [IDX_W-1:0] idx_new;
    logic [LEG_W-1:0] idx_leg;
    logic             unused_addr;

    assign win         = addr[WIN_W-1:0];
    assign unused_addr = ^{addr[ADDR_W-1:WIN_W], win[2:0]};

    assign idx_new = win[WIN_W-1:3];
    assign idx_leg = {win[WIN_W-1:8], win[6:3]};

    always_comb begin
        if (mode_new) begin
            idx = idx_new;
        end else begin
            idx = IDX_W'(idx_leg);
        end
    end
endmodule

// File: rtl/regbr_intercept.sv
module regbr_intercept
    import regbr_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic             mode_new,
    input  logic             is_write,
    input  logic [IDX_W-1:0] idx,
    output verdict_t         verdict
);
    logic [N_SWALLOW-1:0] hit_swallow;
    logic [N_REGION-1:0]  hit_region;

    genvar g;
    generate
        for (g = 0; g < N_SWALLOW; g++) begin : g_swallow
            assign hit_swallow[g] = (idx == IDX_W'(SWALLOW_IDX[g]));
        end
        for (g = 0; g < N_REGION; g++) begin : g_region
            assign hit_region[g] = mode_new ? (idx == IDX_W'(REGION_NEW[g]))
                                            : (idx == IDX_W'(REGION_LEG[g]));
        end
    endgenerate

    always_comb begin
        verdict = '{act: ACT_FWD, src: SRC_NONE};
        if (|hit_swallow) begin
            verdict = '{act: ACT_ZERO, src: SRC_NONE};
        end
        if (idx == IDX_W'(IDX_IDENT)) begin
            verdict = is_write ? '{act: ACT_ZERO, src: SRC_NONE}
                               : '{act: ACT_VALUE, src: SRC_IDENT};
        end
        if (!is_write) begin
            for (int k = 0; k < N_REGION; k++) begin
                if (hit_region[k]) begin
                    verdict = '{act: ACT_VALUE, src: src_e'(3'(int'(SRC_R0B) + k))};
                end
            end
        end
    end
endmodule

// File: rtl/regbr_status.sv
module regbr_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_done,
    input  logic       set_fail,
    input  logic [1:0] clr,
    output logic       done,
    output logic       fail
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            done <= set_done | (done & ~clr[0]);
            fail <= set_fail | (fail & ~clr[1]);
        end
    end
endmodule

// File: rtl/regbr_top.sv
module regbr_top
    import regbr_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int WIN_W  = 35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_new,
    input  logic [63:0]       cfg_ident,
    input  logic [63:0]       cfg_reg0_base,
    input  logic [63:0]       cfg_reg0_span,
    input  logic [63:0]       cfg_reg1_base,
    input  logic [63:0]       cfg_reg1_span,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [4:0]        h_size,
    input  logic [63:0]       h_wdata,
    output logic              h_ready,
    output logic [63:0]       h_rdata,
    output logic              h_err,
    output logic              d_req,
    output logic              d_write,
    output logic [WIN_W-1:0]  d_addr,
    output logic [63:0]       d_wdata,
    input  logic              d_ack,
    input  logic              d_err,
    input  logic [63:0]       d_rdata,
    input  logic [1:0]        st_clr,
    output logic              st_done,
    output logic              st_fail
);
    localparam int IDX_W = WIN_W - 3;

    state_e            state;
    logic [IDX_W-1:0]  idx;
    verdict_t          verdict;
    logic [63:0]       local_val;
    logic [63:0]       rsp_data;
    logic              rsp_err;
    logic              dn_write;
    logic [WIN_W-1:0]  dn_addr;
    logic [63:0]       dn_wdata;
    logic              size_ok;
    logic              set_done;
    logic              set_fail;

    regbr_fold #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_fold (
        .mode_new (mode_new),
        .addr     (h_addr),
        .idx      (idx)
    );

    regbr_intercept #(.IDX_W(IDX_W)) u_icpt (
        .mode_new (mode_new),
        .is_write (h_write),
        .idx      (idx),
        .verdict  (verdict)
    );

    regbr_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_done (set_done),
        .set_fail (set_fail),
        .clr      (st_clr),
        .done     (st_done),
        .fail     (st_fail)
    );

    assign size_ok = (h_size == 5'(ACC_BYTES));

    always_comb begin
        unique case (verdict.src)
            SRC_IDENT: local_val = cfg_ident;
            SRC_R0B:   local_val = cfg_reg0_base;
            SRC_R1B:   local_val = cfg_reg1_base;
            SRC_R0S:   local_val = cfg_reg0_span;
            SRC_R1S:   local_val = cfg_reg1_span;
            default:   local_val = '0;
        endcase
    end

    // Completion events toward the status bits
    always_comb begin
        set_done = 1'b0;
        set_fail = 1'b0;
        if (state == ST_IDLE && h_valid && size_ok && verdict.act != ACT_FWD) begin
            set_done = 1'b1;
        end
        if (state == ST_WAIT && d_ack) begin
            set_done = 1'b1;
            set_fail = d_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
            dn_write <= 1'b0;
            dn_addr  <= '0;
            dn_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (h_valid) begin
                        rsp_err  <= 1'b0;
                        rsp_data <= '0;
                        if (!size_ok) begin
                            rsp_err <= 1'b1;
                            state   <= ST_RESP;
                        end else if (verdict.act == ACT_FWD) begin
                            dn_write <= h_write;
                            dn_addr  <= {idx, 3'b000};
                            dn_wdata <= swap_bytes(h_wdata);
                            state    <= ST_WAIT;
                        end else begin
                            if (verdict.act == ACT_VALUE) begin
                                rsp_data <= swap_bytes(local_val);
                            end
                            state <= ST_RESP;
                        end
                    end
                end
                ST_WAIT: begin
                    if (d_ack) begin
                        rsp_data <= (d_err || dn_write) ? '0 : swap_bytes(d_rdata);
                        state    <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign h_ready = (state == ST_RESP);
    assign h_rdata = rsp_data;
    assign h_err   = rsp_err;
    assign d_req   = (state == ST_WAIT);
    assign d_write = dn_write;
    assign d_addr  = dn_addr;
    assign d_wdata = dn_wdata;
endmodule

// File: rtl/regbr_checker.sv
module regbr_checker #(
    parameter int WIN_W = 35
) (
    input logic             clk,
    input logic             rst,
    input logic             h_ready,
    input logic [63:0]      h_rdata,
    input logic             h_err,
    input logic             d_req,
    input logic             d_write,
    input logic [WIN_W-1:0] d_addr,
    input logic [63:0]      d_wdata,
    input logic             d_ack,
    input logic             d_err,
    input logic [1:0]       st_clr,
    input logic             st_done,
    input logic             st_fail
);
    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        h_ready |=> !h_ready);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_write) && $stable(d_wdata)));

    p_one_open_r12: assert property (@(posedge clk) disable iff (rst)
        !(d_req && h_ready));

    p_addr_align_r3: assert property (@(posedge clk) disable iff (rst)
        d_req |-> (d_addr[2:0] == 3'b000));

    p_size_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (h_ready && h_err) |-> (h_rdata == 64'd0));

    p_fail_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(st_fail) |-> st_done);

    p_fail_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(st_fail) |-> $past(d_ack && d_err));

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (st_done && !st_clr[0]) |=> st_done);

    p_fail_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (st_fail && !st_clr[1]) |=> st_fail);
endmodule

bind regbr_top regbr_checker #(.WIN_W(WIN_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .h_ready (h_ready),
    .h_rdata (h_rdata),
    .h_err   (h_err),
    .d_req   (d_req),
    .d_write (d_write),
    .d_addr  (d_addr),
    .d_wdata (d_wdata),
    .d_ack   (d_ack),
    .d_err   (d_err),
    .st_clr  (st_clr),
    .st_done (st_done),
    .st_fail (st_fail)
);

// File: tb/sim_regbr_top.sv
module sim_regbr_top;
    localparam int AW = 40;
    localparam int WW = 35;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_new = 1'b1;
    logic [63:0]   cfg_ident = 64'h0123_4567_89AB_CDEF;
    logic [63:0]   cfg_reg0_base = 64'h0000_0020_0000_0000;
    logic [63:0]   cfg_reg0_span = 64'h0000_0000_0040_0000;
    logic [63:0]   cfg_reg1_base = 64'h0000_0030_1000_0000;
    logic [63:0]   cfg_reg1_span = 64'h0000_0000_0080_0000;
    logic          h_valid = 1'b0;
    logic          h_write = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [4:0]    h_size = 5'd8;
    logic [63:0]   h_wdata = '0;
    logic          h_ready;
    logic [63:0]   h_rdata;
    logic          h_err;
    logic          d_req;
    logic          d_write;
    logic [WW-1:0] d_addr;
    logic [63:0]   d_wdata;
    logic          d_ack = 1'b0;
    logic          d_err = 1'b0;
    logic [63:0]   d_rdata = '0;
    logic [1:0]    st_clr = 2'b00;
    logic          st_done;
    logic          st_fail;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    regbr_top #(.ADDR_W(AW), .WIN_W(WW)) u0 (.*);

    // Scoreboard queues
    logic [63:0]   e_data [$];
    logic          e_err  [$];
    logic          e_done [$];
    logic          e_fail [$];
    string         e_tag  [$];
    logic [WW-1:0] q_addr  [$];
    logic          q_write [$];
    logic [63:0]   q_wdata [$];
    logic [63:0]   q_rdata [$];
    logic          q_err   [$];
    int            q_lat   [$];
    string         q_tag   [$];

    logic  m_done = 1'b0;
    logic  m_fail = 1'b0;
    string cur_tag = "R12";

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[63-8*i -: 8] = v[8*i +: 8];
        return r;
    endfunction

    function automatic logic [AW-1:0] new_a(input logic [31:0] i);
        return AW'(i) << 3;
    endfunction

    function automatic logic [AW-1:0] leg_a(input logic [31:0] i, input bit b7);
        return ((AW'(i) >> 4) << 8) | (AW'(i & 32'hF) << 3) | (AW'(b7) << 7);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares host responses against the scoreboard
    always @(negedge clk) begin
        if (!rst && h_ready) begin
            if (e_data.size() == 0) begin
                check(1'b0, cur_tag, "unexpected h_ready", 64'd1, 64'd0);
            end else begin
                logic [63:0] xd;
                logic xe, xdn, xf;
                string t;
                xd = e_data.pop_front(); xe = e_err.pop_front();
                xdn = e_done.pop_front(); xf = e_fail.pop_front(); t = e_tag.pop_front();
                check(h_rdata == xd, t, "h_rdata", h_rdata, xd);
                check(h_err == xe, t, "h_err", 64'(h_err), 64'(xe));
                check(st_done == xdn, t, "st_done", 64'(st_done), 64'(xdn));
                check(st_fail == xf, t, "st_fail", 64'(st_fail), 64'(xf));
            end
        end
    end

    // Downstream target model
    bit serving = 1'b0;
    int lat_left = 0;
    logic [63:0] cur_rd;
    logic cur_er;
    always @(negedge clk) begin
        if (d_ack) begin
            d_ack = 1'b0;
            d_err = 1'b0;
        end else if (!rst && d_req) begin
            if (!serving) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected downstream request", 64'(d_addr), 64'd0);
                    cur_rd = '0; cur_er = 1'b0; lat_left = 0;
                end else begin
                    logic [WW-1:0] xa; logic xw; logic [63:0] xwd; string t;
                    xa = q_addr.pop_front(); xw = q_write.pop_front();
                    xwd = q_wdata.pop_front(); t = q_tag.pop_front();
                    cur_rd = q_rdata.pop_front(); cur_er = q_err.pop_front();
                    lat_left = q_lat.pop_front();
                    check(d_addr == xa, t, "d_addr", 64'(d_addr), 64'(xa));
                    check(d_write == xw, t, "d_write", 64'(d_write), 64'(xw));
                    if (xw) check(d_wdata == xwd, t, "d_wdata", d_wdata, xwd);
                end
                serving = 1'b1;
            end
            if (lat_left == 0) begin
                d_ack = 1'b1;
                d_err = cur_er;
                d_rdata = cur_rd;
                serving = 1'b0;
            end else begin
                lat_left--;
            end
        end
    end

    // Driver: pushes expectations, then performs one host access
    task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [4:0] sz,
                          input logic [63:0] wd, input bit fwd, input logic [WW-1:0] xa,
                          input logic [63:0] ds_rd, input bit ds_er, input int lat,
                          input logic [63:0] xd, input bit xe, input string tag);
        int waited;
        if (!xe) begin
            m_done = 1'b1;
            if (fwd && ds_er) m_fail = 1'b1;
        end
        e_data.push_back(xd); e_err.push_back(xe);
        e_done.push_back(m_done); e_fail.push_back(m_fail); e_tag.push_back(tag);
        if (fwd) begin
            q_addr.push_back(xa); q_write.push_back(wr); q_wdata.push_back(bswap(wd));
            q_rdata.push_back(ds_rd); q_err.push_back(ds_er); q_lat.push_back(lat);
            q_tag.push_back(tag);
        end
        cur_tag = tag;
        h_valid = 1'b1; h_write = wr; h_addr = addr; h_size = sz; h_wdata = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!h_ready);
        h_valid = 1'b0;
        check(waited == (fwd ? 2 + lat : 1), "R12", {"response latency ", tag},
              64'(waited), 64'(fwd ? 2 + lat : 1));
        @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] bits, input string tag);
        st_clr = bits;
        @(negedge clk);
        st_clr = 2'b00;
        if (bits[0]) m_done = 1'b0;
        if (bits[1]) m_fail = 1'b0;
        check(st_done == m_done, tag, "st_done after clear", 64'(st_done), 64'(m_done));
        check(st_fail == m_fail, tag, "st_fail after clear", 64'(st_fail), 64'(m_fail));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!h_ready && !d_req && !st_done && !st_fail, "R12", "reset state",
              {60'd0, h_ready, d_req, st_done, st_fail}, 64'd0);

        // New-generation mode
        mode_new = 1'b1;
        access(0, new_a(32'h000F000F), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_ident), 0, "R6 R5 ident read");
        access(0, new_a(32'h000F000F) | (AW'(1) << 36) | (AW'(1) << 39), 8, 0, 0, 0, 0, 0, 0,
               bswap(cfg_ident), 0, "R2 high bits ignored");
        access(1, new_a(32'h000F000F), 8, 64'hFFFF_0000_FFFF_0000, 0, 0, 0, 0, 0, 0, 0, "R6 ident write dropped");
        access(0, new_a(32'h000F000F), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_ident), 0, "R6 ident unchanged");
        access(0, new_a(32'h05012B00), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_reg0_base), 0, "R7 reg0 base new");
        access(0, new_a(32'h05012B06), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_reg1_span), 0, "R7 reg1 span new");
        access(0, new_a(32'h02013F00), 8, 0, 1, WW'(32'h02013F00) << 3, 64'h1111_2222_3333_4444, 0, 1,
               bswap(64'h1111_2222_3333_4444), 0, "R7 legacy index forwarded in new mode");
        access(1, new_a(32'h05012B02), 8, 64'h0102_0304_0506_0708, 1, WW'(32'h05012B02) << 3, 0, 0, 0,
               0, 0, "R7 R5 region write forwarded");
        access(0, new_a(32'h00090013), 8, 0, 0, 0, 0, 0, 0, 0, 0, "R8 swallow read");
        access(1, new_a(32'h01010C03), 8, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, "R8 swallow write");
        access(0, new_a(32'h00123456) | AW'(5), 8, 0, 1, WW'(32'h00123456) << 3,
               64'hA1B2_C3D4_E5F6_0718, 0, 3, bswap(64'hA1B2_C3D4_E5F6_0718), 0, "R3 R5 R9 forwarded read");
        access(0, new_a(32'h00ABCD00), 8, 0, 1, WW'(32'h00ABCD00) << 3, 64'h5555_5555_5555_5555, 1, 2,
               0, 0, "R10 read error");
        clear(2'b10, "R11 clear fail only");
        clear(2'b01, "R11 clear done");

        access(0, new_a(32'h000F000F), 5'd4, 0, 0, 0, 0, 0, 0, 0, 1, "R1 size 4");
        access(1, new_a(32'h00001000), 5'd16, 64'h1, 0, 0, 0, 0, 0, 0, 1, "R1 size 16");
        check(!st_done && !st_fail, "R1", "status untouched by size error",
              {62'd0, st_done, st_fail}, 64'd0);

        access(1, new_a(32'h00002000), 8, 64'h0F0E_0D0C_0B0A_0908, 1, WW'(32'h00002000) << 3, 0, 1, 0,
               0, 0, "R10 write error");
        access(0, new_a(32'h00002008), 8, 0, 1, WW'(32'h00002008) << 3, 64'h7, 0, 0,
               bswap(64'h7), 0, "R11 fail stays after good access");

        // Legacy mode
        mode_new = 1'b0;
        access(0, leg_a(32'h02013F00, 1), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_reg0_base), 0, "R4 R7 reg0 base legacy");
        access(0, leg_a(32'h02013F04, 0), 8, 0, 0, 0, 0, 0, 0, bswap(cfg_reg0_span), 0, "R7 reg0 span legacy");
        access(0, leg_a(32'h05012B02, 0), 8, 0, 1, WW'(32'h05012B02) << 3, 64'h9, 0, 0,
               bswap(64'h9), 0, "R7 new index forwarded in legacy mode");
        access(0, leg_a(32'h000ABCDE, 1) | AW'(5), 8, 0, 1, WW'(32'h000ABCDE) << 3,
               64'h0123_0000_0000_4567, 0, 1, bswap(64'h0123_0000_0000_4567), 0, "R4 legacy fold");
        access(0, leg_a(32'h02020009, 1), 8, 0, 0, 0, 0, 0, 0, 0, 0, "R8 swallow legacy");
        access(0, leg_a(32'h000F000F, 0) | (AW'(1) << 37), 8, 0, 0, 0, 0, 0, 0,
               bswap(cfg_ident), 0, "R6 R2 ident legacy");
        clear(2'b11, "R11 clear both");

        repeat (4) @(negedge clk);
        check(e_data.size() == 0 && q_addr.size() == 0, "R12", "scoreboard drained",
              64'(e_data.size() + q_addr.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule